// File: doc/BRIEF.md
# Serial Register Programming Port

This block gives a host a narrow serial path into a bank of sixteen 10-bit configuration registers. The host pulls a frame-enable line low and sends 16-bit words on a data line, one bit per rising edge of a serial clock. When frame-enable returns high, the most recent 16 bits are taken as one command. The command either writes a register or asks for a register's contents. A read answer comes back on the serial output during the next frame.

All serial inputs are sampled by a faster system clock, so the whole block runs in one clock domain. The serial output always carries the bit that is leaving the top of the shift register. Several ports can therefore be wired output-to-input under a shared serial clock and frame line. With N ports in the chain, the host shifts 16·N bits per frame. The register contents drive the rest of the chip through one flat output bus.

Top module: `serial_ctrl_port`

## Requirements
- R1: A command word is sent MSB first. In that word, bits 15:12 select the register, bit 11 chooses the access (0 = write, 1 = read), and bits 9:0 carry the data.
- R2: When frame-enable rises, a write command stores data bits 9:0 in the selected register, which appears on `ctrl_regs_o[addr*10 +: 10]`. All other registers keep their values.
- R3: A read command changes no register. In the next frame, the first 16 bits on `ctl_dout` are {addr, 1, 0, stored value}.
- R4: While frame-enable is high, serial clock edges and data have no effect on the registers or on the shift-register contents.
- R5: A frame whose bit count is not 16 acts on the last 16 bits received. Bits received before those are pushed out, and bits left from the previous word fill in any shortfall.
- R6: `ctl_dout` presents the shift-register MSB. It is loaded when frame-enable falls and after each falling serial clock edge. After a write, the next frame's first 16 output bits echo the written command word, which is what allows chaining.
- R7: A write to register 0 with data bit 9 set clears every register to zero, including register 0 itself.
- R8: After hardware reset, every register output is 0, `ctl_dout` is 0, and the shift register holds 0.
- R9: Bit 10 of a command is ignored: a write with bit 10 set stores exactly the same data as one with it clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples all serial lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ctl_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ctl_latch_n | input | 1 | Active-low frame enable; the rising edge applies the command |
| ctl_din | input | 1 | Serial command input |
| ctl_dout | output | 1 | Serial output (read-back data or pass-through for chaining) |
| ctrl_regs_o | output | 160 | Sixteen 10-bit registers; register k occupies bits k*10+9 : k*10 |

## Verification
A corrupted shift register shows up one frame later, either as a wrong stored value or as a wrong echo on `ctl_dout`, because every word is bit-exact at the output during the following frame. A stray write enable or a bad address decode changes some slice of `ctrl_regs_o` within a few system clocks of frame-enable rising. Each test compares all sixteen slices against a model, so a write that lands in the wrong register, or one that is lost, is caught at once. Edges that should be ignored, and frames of 20 or 8 bits, are checked through the echo and through the register bus, so a counter-based or edge-gating fault shows at the ports.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int FRAME_W  = 16;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 10;
  localparam int NUM_REGS = 1 << ADDR_W;
  localparam int SOFT_RST_ADDR = 0;
  localparam int SOFT_RST_BIT  = 9;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              rd;
    logic              rsvd;
    logic [DATA_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = d;
      end else begin : g_rest
        always_comb stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/scp_shifter.sv
module scp_shifter
  import scp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sdi,
  input  logic               shift_en,
  input  logic               out_en,
  input  logic               frame_start,
  input  logic               preload_en,
  input  logic [FRAME_W-1:0] preload_word,
  output logic [FRAME_W-1:0] word,
  output logic               sdo
);
  logic [FRAME_W-1:0] word_d;
  logic               sdo_d;
  logic               sdo_q;

  always_comb begin
    word_d = word;
    if (preload_en)    word_d = preload_word;
    else if (shift_en) word_d = {word[FRAME_W-2:0], sdi};
  end

  always_comb begin
    sdo_d = sdo_q;
    if (frame_start || out_en) sdo_d = word[FRAME_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word  <= '0;
      sdo_q <= 1'b0;
    end else begin
      word  <= word_d;
      sdo_q <= sdo_d;
    end
  end

  assign sdo = sdo_q;

  // R4: contents move only on a gated shift or a preload
  p_word_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !preload_en) |=> $stable(word));

  // R6: output bit changes only at frame start or after a falling serial edge
  p_sdo_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_en && !frame_start) |=> $stable(sdo));
endmodule

// File: rtl/scp_regfile.sv
module scp_regfile
  import scp_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [ADDR_W-1:0]              waddr,
  input  logic [DATA_W-1:0]              wdata,
  output logic [NUM_REGS-1:0][DATA_W-1:0] regs_o
);
  logic soft_clr;

  always_comb soft_clr = we && (waddr == ADDR_W'(SOFT_RST_ADDR)) && wdata[SOFT_RST_BIT];

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic [DATA_W-1:0] val_q;
      logic [DATA_W-1:0] val_d;
      logic              hit;

      always_comb begin
        hit   = we && (waddr == ADDR_W'(i));
        val_d = val_q;
        if (soft_clr) val_d = '0;
        else if (hit) val_d = wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
      end

      assign regs_o[i] = val_q;
    end
  endgenerate

  // R2: without a write strobe the bank does not move
  p_bank_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(regs_o));

  // R2: an ordinary write lands in the addressed slot
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !soft_clr) |=> (regs_o[$past(waddr)] == $past(wdata)));

  // R7: the software clear empties the whole bank
  p_soft_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (regs_o == '0));
endmodule

// File: rtl/serial_ctrl_port.sv
module serial_ctrl_port
  import scp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ctl_clk,
  input  logic                       ctl_latch_n,
  input  logic                       ctl_din,
  output logic                       ctl_dout,
  output logic [NUM_REGS*DATA_W-1:0] ctrl_regs_o
);
  localparam logic [2:0] SYNC_RST = 3'b010; // {clk, latch_n, din}

  // reset: asserted at once, released on a clock edge
  logic rst_meta, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_core_n <= rst_meta;
    end
  end

  logic [2:0] pins_s;
  scp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk  (clk),
    .rst_n(rst_core_n),
    .d    ({ctl_clk, ctl_latch_n, ctl_din}),
    .q    (pins_s)
  );

  logic sclk_s, latch_s, din_s;
  assign {sclk_s, latch_s, din_s} = pins_s;

  logic sclk_q, latch_q;
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      sclk_q  <= 1'b0;
      latch_q <= 1'b1;
    end else begin
      sclk_q  <= sclk_s;
      latch_q <= latch_s;
    end
  end

  logic sclk_rise, sclk_fall, latch_fall, latch_rise;
  always_comb begin
    sclk_rise  = !latch_s && sclk_s && !sclk_q;
    sclk_fall  = !latch_s && !sclk_s && sclk_q;
    latch_fall = !latch_s && latch_q;
    latch_rise = latch_s && !latch_q;
  end

  logic [FRAME_W-1:0]              word;
  cmd_t                            cmd;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic                            wr_en, rd_en;
  logic [FRAME_W-1:0]              rd_word;

  always_comb begin
    cmd     = cmd_t'(word);
    wr_en   = latch_rise && !cmd.rd;
    rd_en   = latch_rise && cmd.rd;
    rd_word = {cmd.addr, 1'b1, 1'b0, regs[cmd.addr]};
  end

  scp_shifter u_shift (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .sdi         (din_s),
    .shift_en    (sclk_rise),
    .out_en      (sclk_fall),
    .frame_start (latch_fall),
    .preload_en  (rd_en),
    .preload_word(rd_word),
    .word        (word),
    .sdo         (ctl_dout)
  );

  scp_regfile u_regs (
    .clk   (clk),
    .rst_n (rst_core_n),
    .we    (wr_en),
    .waddr (cmd.addr),
    .wdata (cmd.data),
    .regs_o(regs)
  );

  assign ctrl_regs_o = regs;

  // R3: a read reloads the shift register with the answer word
  p_read_preload_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    rd_en |=> (word[FRAME_W-1 -: ADDR_W] == $past(cmd.addr)) && word[DATA_W+1] && !word[DATA_W]);

  // R4: with frame-enable high, no shifting occurs
  p_idle_no_shift_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (latch_s && latch_q) |=> $stable(word));
endmodule

// File: tb/serial_ctrl_port_tb.sv
module serial_ctrl_port_tb;
  localparam int HALF = 8;
  localparam int NVEC = 8;
  localparam logic [15:0] VEC [NVEC] = '{
    16'h1155, 16'h23FF, 16'h3000, 16'h64AB,
    16'hF2AA, 16'h8001, 16'h0155, 16'hA1C3
  };

  logic clk = 1'b0;
  logic rst_n, sclk, latch_n, sdi, sdo;
  logic [159:0] regs;
  logic [9:0] model [16];
  int checks = 0;
  int errors = 0;
  logic [63:0] got;

  always #2 clk = ~clk;

  serial_ctrl_port u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_clk(sclk), .ctl_latch_n(latch_n),
    .ctl_din(sdi), .ctl_dout(sdo), .ctrl_regs_o(regs)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    logic ok;
    ok = 1'b1;
    for (int a = 0; a < 16; a++)
      if (regs[a*10 +: 10] !== model[a]) begin
        ok = 1'b0;
        $display("FAIL %s reg %0d actual %h expected %h", req, a, regs[a*10 +: 10], model[a]);
      end
    checks++;
    if (!ok) errors++;
  endtask

  task automatic frame(input logic [63:0] bits, input int n, output logic [63:0] rx);
    rx = '0;
    latch_n = 1'b0;
    wait_n(HALF);
    for (int i = 0; i < n; i++) begin
      sdi = bits[n-1-i];
      wait_n(HALF);
      rx = {rx[62:0], sdo};
      sclk = 1'b1;
      wait_n(HALF);
      sclk = 1'b0;
    end
    wait_n(HALF);
    latch_n = 1'b1;
    wait_n(2*HALF);
  endtask

  task automatic apply_write(input logic [15:0] w);
    frame({48'h0, w}, 16, got);
    if (!w[11] && w[15:12] == 4'h0 && w[9]) begin
      for (int a = 0; a < 16; a++) model[a] = '0;
    end else if (!w[11]) begin
      model[w[15:12]] = w[9:0];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sclk = 1'b0; latch_n = 1'b1; sdi = 1'b0;
    for (int a = 0; a < 16; a++) model[a] = '0;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(6);
    // R8: reset state
    check("R8 regs", {31'd0, regs == '0}, 32'd1);
    check("R8 sdo", {31'd0, sdo}, 32'd0);

    // R1 R2 R9: table of writes, all registers compared after each
    for (int v = 0; v < NVEC; v++) begin
      apply_write(VEC[v]);
      check_regs("R2 R1 R9 table write");
    end

    // R6: echo of the last written word; R3: read of register 8
    frame({48'h0, 16'h8800}, 16, got);
    check("R6 echo after write", {16'h0, got[15:0]}, {16'h0, 16'hA1C3});
    check_regs("R3 read leaves regs");
    frame({48'h0, 16'hF800}, 16, got);
    check("R3 read word reg8", {16'h0, got[15:0]}, {16'h0, 16'h8801});
    frame({48'h0, 16'hF800}, 16, got);
    check("R3 read word regF", {16'h0, got[15:0]}, {16'h0, 16'hFAAA});
    check_regs("R3 regs after reads");

    // R4: edges with frame-enable high are ignored
    apply_write(16'h5123);
    for (int k = 0; k < 6; k++) begin
      sdi = k[0];
      wait_n(HALF); sclk = 1'b1; wait_n(HALF); sclk = 1'b0;
    end
    wait_n(HALF);
    check_regs("R4 idle edges regs");
    frame({48'h0, 16'h8800}, 16, got);
    check("R4 shift reg untouched", {16'h0, got[15:0]}, {16'h0, 16'h5123});

    // R5: a 20-bit frame applies the last 16 bits
    frame({44'h0, 4'hF, 16'h4055}, 20, got);
    model[4] = 10'h055;
    check_regs("R5 long frame");
    // R5: an 8-bit frame merges with the previous word
    apply_write(16'h1025);
    frame({56'h0, 8'h77}, 8, got);
    model[2] = 10'h177;
    check_regs("R5 short frame");

    // R7: software clear
    apply_write(16'h0200);
    check_regs("R7 soft clear");
    check("R7 all zero", {31'd0, regs == '0}, 32'd1);

    // R8: hardware reset mid-use
    apply_write(16'h7333);
    check_regs("R8 pre-reset write");
    rst_n = 1'b0;
    wait_n(3);
    for (int a = 0; a < 16; a++) model[a] = '0;
    check_regs("R8 regs in reset");
    rst_n = 1'b1;
    wait_n(6);
    check("R8 sdo after reset", {31'd0, sdo}, 32'd0);
    frame({48'h0, 16'h8800}, 16, got);
    check("R8 shift reg cleared", {16'h0, got[15:0]}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule